// File: doc/BRIEF.md
# Extended Register Access Sequencer

This block reaches a 16-bit indirect register space on a peripheral that only exposes a handful of 8-bit standard registers. A requester hands over one command (read, write, or sensitivity update), and the block turns it into a fixed series of standard-register accesses on a downstream register port. It then polls the peripheral's control register until it reads zero, waiting a fixed interval between attempts. It finishes with a one-cycle `done` pulse, which carries the read result, or with a one-cycle `err` pulse when the attempt budget runs out.

The sensitivity command is a read-modify-write of the indirect configuration byte (default address 0x0187). It keeps bits 5:0, replaces bits 7:6 with the requested attenuation level, writes the byte back, and then clears the peripheral's status register. The poll spacing is derived from the clock frequency parameter, so the same RTL serves any clock. The serial link that carries the downstream port is not part of this block.

Top module: `xreg_seq`

## Requirements
- R1: A write command (`req_op` = 2'b01) issues exactly these register writes, in this order: 0x1B ← data, 0x1C ← address[15:8], 0x1D ← address[7:0], 0x1E ← 0x02. Polling follows.
- R2: A read command (`req_op` = 2'b00) issues these writes in order: 0x1C ← address[15:8], 0x1D ← address[7:0], 0x1E ← 0x01. It polls, then reads register 0x1B and presents that byte on `rdata` in the `done` cycle.
- R3: A poll is a read of register 0x1E, and the command counts as complete when that read returns 0x00. When a poll returns a nonzero value, the next poll starts no sooner than POLL_US·CLK_HZ/10⁶ cycles later.
- R4: After POLL_TRIES polls in a row that all return nonzero, the block pulses `err` and issues no further register accesses for that command. No `done` pulse follows.
- R5: A sensitivity command (`req_op` = 2'b10, level on `req_level`) does the following in order:
  - It reads the configuration byte at CFG_ADDR as in R2.
  - It writes (byte & 0x3F) | (level << 6) back as in R1, so level 0..3 gives codes 0x00/0x40/0x80/0xC0.
  - It polls, then writes 0x00 to register 0x02.
  - `rdata` carries the new byte in the `done` cycle.
  A write command returns `rdata` = 0x00.
- R6: `busy` is high from the cycle after a request is accepted up to the cycle in which `done` or `err` pulses, and it is low in that cycle. `done` and `err` are one-cycle pulses and are never high together.
- R7: A request that arrives while `busy` is high has no effect, and so does a request with `req_op` = 2'b11.
- R8: After reset, `busy`, `done`, `err` and `reg_valid` are low. `rdata` is 0x00 in every cycle without a `done` pulse.
- R9: While `reg_valid` is high and `reg_ready` is low, `reg_valid`, `reg_we`, `reg_addr` and `reg_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request, sampled only while idle |
| req_op | input | 2 | 00 read, 01 write, 10 sensitivity update, 11 no operation |
| req_addr | input | 16 | Indirect address for read and write |
| req_wdata | input | 8 | Data byte for write |
| req_level | input | 2 | Attenuation level for the sensitivity update |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rdata | output | 8 | Result byte, valid with `done` |
| reg_valid | output | 1 | Standard-register access request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | 5 | Standard-register address |
| reg_wdata | output | 8 | Write data |
| reg_ready | input | 1 | Downstream accepts the access this cycle |
| reg_rvalid | input | 1 | Read data returned |
| reg_rdata | input | 8 | Returned read byte |

## Verification
If the step index is corrupted, the register-access order on the downstream port is wrong, and this shows at the very next handshake. The bench compares every logged write of every command against its own list. A wrong retry counter shows as an extra or a missing poll, or as an `err` on the wrong attempt, within one poll interval; commands with 0 to 6 busy polls, straddling the limit of 5, expose it. A corrupted captured byte shows in `rdata` on the `done` cycle, and for the sensitivity command it shows earlier, in the write-back data. A latch enable that is wrong shows as an accepted mid-command request, which starts extra accesses after `done`.

// File: rtl/xreg_pkg.sv
// Shared types and constants for the extended register access sequencer.
// Assumes a peripheral exposing 5-bit standard register addresses.
package xreg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SENSE = 2'b10,
        OP_NONE  = 2'b11
    } xreg_op_e;

    typedef enum logic [1:0] {
        K_WR,
        K_RD,
        K_POLL,
        K_END
    } step_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [4:0]  addr;
        logic [7:0]  data;
    } step_t;

    localparam int IDX_W = 4;

    localparam logic [4:0] A_VALUE  = 5'h1B;
    localparam logic [4:0] A_HI     = 5'h1C;
    localparam logic [4:0] A_LO     = 5'h1D;
    localparam logic [4:0] A_CTRL   = 5'h1E;
    localparam logic [4:0] A_STATUS = 5'h02;

    localparam logic [7:0] CMD_READ  = 8'h01;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] KEEP_MASK = 8'h3F;

endpackage

// File: rtl/xreg_plan.sv
// Step generator: maps (command, step index) to one downstream access.
// Purely combinational; assumes the index advances one step at a time
// and that the captured byte is valid once its read step has retired.
module xreg_plan
    import xreg_pkg::*;
(
    input  xreg_op_e          op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        cap,
    input  logic [1:0]        level,
    output step_t             step,
    output logic [7:0]        cfg_byte
);

    // New configuration byte: keep low bits, insert attenuation level.
    always_comb cfg_byte = (cap & KEEP_MASK) | {level, 6'b0};

    // Step table per command.
    always_comb begin
        step = '{kind: K_END, addr: 5'h00, data: 8'h00};
        case (op)
            OP_WRITE: begin
                case (idx)
                    4'd0: step = '{kind: K_WR,   addr: A_VALUE, data: wdata};
                    4'd1: step = '{kind: K_WR,   addr: A_HI,    data: addr[15:8]};
                    4'd2: step = '{kind: K_WR,   addr: A_LO,    data: addr[7:0]};
                    4'd3: step = '{kind: K_WR,   addr: A_CTRL,  data: CMD_WRITE};
                    4'd4: step = '{kind: K_POLL, addr: A_CTRL,  data: 8'h00};
                    default: ;
                endcase
            end
            OP_READ, OP_SENSE: begin
                case (idx)
                    4'd0: step = '{kind: K_WR,   addr: A_HI,    data: addr[15:8]};
                    4'd1: step = '{kind: K_WR,   addr: A_LO,    data: addr[7:0]};
                    4'd2: step = '{kind: K_WR,   addr: A_CTRL,  data: CMD_READ};
                    4'd3: step = '{kind: K_POLL, addr: A_CTRL,  data: 8'h00};
                    4'd4: step = '{kind: K_RD,   addr: A_VALUE, data: 8'h00};
                    default: ;
                endcase
                if (op == OP_SENSE) begin
                    case (idx)
                        4'd5:  step = '{kind: K_WR,   addr: A_VALUE,  data: cfg_byte};
                        4'd6:  step = '{kind: K_WR,   addr: A_HI,     data: addr[15:8]};
                        4'd7:  step = '{kind: K_WR,   addr: A_LO,     data: addr[7:0]};
                        4'd8:  step = '{kind: K_WR,   addr: A_CTRL,   data: CMD_WRITE};
                        4'd9:  step = '{kind: K_POLL, addr: A_CTRL,   data: 8'h00};
                        4'd10: step = '{kind: K_WR,   addr: A_STATUS, data: 8'h00};
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xreg_tick.sv
// One-shot interval timer: expire pulses CYCLES cycles after start.
// Assumes start is not raised again while the timer is running.
module xreg_tick #(
    parameter int unsigned CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Countdown from CYCLES-1 to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    // Expiry when the count reaches zero.
    always_comb expire = run_q && (cnt_q == '0);

    assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= CW'(CYCLES - 1)));

endmodule

// File: rtl/xreg_seq.sv
// Extended register access sequencer top.
// Accepts one command while idle, walks the step table onto the downstream
// register port, polls the control register with a timed gap and finishes
// with a done or err pulse. Assumes one outstanding downstream read at most.
module xreg_seq
    import xreg_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned POLL_US    = 10_000,
    parameter int unsigned POLL_TRIES = 5,
    parameter logic [15:0] CFG_ADDR   = 16'h0187
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic [1:0]  req_level,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  rdata,
    output logic        reg_valid,
    output logic        reg_we,
    output logic [4:0]  reg_addr,
    output logic [7:0]  reg_wdata,
    input  logic        reg_ready,
    input  logic        reg_rvalid,
    input  logic [7:0]  reg_rdata
);

    localparam longint unsigned POLL_PROD   = (64'(CLK_HZ) * 64'(POLL_US)) / 64'd1_000_000;
    localparam int unsigned     POLL_CYCLES = (POLL_PROD == 0) ? 1 : 32'(POLL_PROD);
    localparam int              TRY_W       = $clog2(POLL_TRIES + 1);

    seq_state_e         state_q;
    xreg_op_e           op_q;
    logic [15:0]        addr_q;
    logic [7:0]         wdata_q;
    logic [1:0]         level_q;
    logic [7:0]         cap_q;
    logic [IDX_W-1:0]   idx_q;
    logic [TRY_W-1:0]   tries_q;
    logic               done_q;
    logic               err_q;
    logic [7:0]         rdata_q;

    step_t              step;
    logic [7:0]         cfg_byte;
    logic               poll_retry;
    logic               gap_over;
    logic [7:0]         result;

    xreg_plan u_plan (
        .op       (op_q),
        .idx      (idx_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .cap      (cap_q),
        .level    (level_q),
        .step     (step),
        .cfg_byte (cfg_byte)
    );

    // A nonzero poll with attempts left arms the gap timer.
    always_comb poll_retry = (state_q == S_WAIT) && reg_rvalid && (step.kind == K_POLL)
                             && (reg_rdata != 8'h00)
                             && (tries_q != TRY_W'(POLL_TRIES - 1));

    xreg_tick #(.CYCLES(POLL_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (poll_retry),
        .expire (gap_over)
    );

    // Result byte reported with done.
    always_comb begin
        case (op_q)
            OP_READ:  result = cap_q;
            OP_SENSE: result = cfg_byte;
            default:  result = 8'h00;
        endcase
    end

    // Main sequencer: accept, issue, await data, wait poll gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
            level_q <= '0;
            cap_q   <= '0;
            idx_q   <= '0;
            tries_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid && (xreg_op_e'(req_op) != OP_NONE)) begin
                        op_q    <= xreg_op_e'(req_op);
                        addr_q  <= (xreg_op_e'(req_op) == OP_SENSE) ? CFG_ADDR : req_addr;
                        wdata_q <= req_wdata;
                        level_q <= req_level;
                        idx_q   <= '0;
                        tries_q <= '0;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (step.kind == K_END) begin
                        done_q  <= 1'b1;
                        rdata_q <= result;
                        state_q <= S_IDLE;
                    end else if (reg_ready) begin
                        if (step.kind == K_WR) idx_q <= idx_q + IDX_W'(1);
                        else                   state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (reg_rvalid) begin
                        if (step.kind == K_RD) begin
                            cap_q   <= reg_rdata;
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= S_ISSUE;
                        end else if (reg_rdata == 8'h00) begin
                            idx_q   <= idx_q + IDX_W'(1);
                            tries_q <= '0;
                            state_q <= S_ISSUE;
                        end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
                            err_q   <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            tries_q <= tries_q + TRY_W'(1);
                            state_q <= S_GAP;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_over) state_q <= S_ISSUE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Port drive from state and current step.
    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = done_q;
        err       = err_q;
        rdata     = rdata_q;
        reg_valid = (state_q == S_ISSUE) && (step.kind != K_END);
        reg_we    = (step.kind == K_WR);
        reg_addr  = step.addr;
        reg_wdata = step.data;
    end

    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr)
                                       && $stable(reg_wdata) && $stable(reg_we)));

    assert_pulse_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_pulse_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (!busy && $past(busy)));

    assert_ignore_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(addr_q) && $stable(op_q) && $stable(wdata_q)));

    assert_try_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TRY_W'(POLL_TRIES));

    assert_access_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid |-> busy);

endmodule

// File: tb/test_xreg_seq.sv
`timescale 1ns/1ps
module test_xreg_seq;

    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int unsigned POLL_US = 6;
    localparam int TRIES = 5;
    localparam int CYC = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  req_level = '0;
    logic        busy, done, err;
    logic [7:0]  rdata;
    logic        reg_valid, reg_we;
    logic [4:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_ready = 1'b0;
    logic        reg_rvalid = 1'b0;
    logic [7:0]  reg_rdata = '0;

    xreg_seq #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US), .POLL_TRIES(TRIES)) i_xreg_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_level(req_level),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Peripheral model state.
    logic [7:0] ext_mem [int];
    logic [7:0] p_val = '0, p_hi = '0, p_lo = '0, p_ctrl = '0;
    int         p_left = 0;
    int         busy_polls = 0;
    int         pend = 0;
    logic [7:0] pend_data = '0;
    logic [4:0] wr_a [0:31];
    logic [7:0] wr_d [0:31];
    int         wr_n = 0;
    int         poll_n = 0;
    int         last_poll = -1;
    int         min_gap = 1000000;
    logic       pv = 0, pr = 0, pw = 0;
    logic [4:0] pa = '0;
    logic [7:0] pd = '0;

    function automatic logic [7:0] peek(input int a);
        logic [15:0] w;
        w = a[15:0];
        return ext_mem.exists(a) ? ext_mem[a] : (w[7:0] ^ w[15:8] ^ 8'h3C);
    endfunction

    // Downstream responder and R9 hold monitor, all at the falling edge.
    always @(negedge clk) begin
        bit rdy;
        if (rst_n && pv && !pr) begin
            check("R9", "valid held", {31'd0, reg_valid}, 1);
            check("R9", "addr held", {27'd0, reg_addr}, {27'd0, pa});
            check("R9", "data/we held", {23'd0, reg_we, reg_wdata}, {23'd0, pw, pd});
        end
        reg_rvalid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                reg_rvalid = 1'b1;
                reg_rdata  = pend_data;
            end
        end
        rdy = ($urandom % 4) != 0;
        reg_ready = rdy;
        pv = reg_valid; pr = rdy; pa = reg_addr; pd = reg_wdata; pw = reg_we;
        if (rst_n && reg_valid && rdy) begin
            if (reg_we) begin
                if (wr_n < 32) begin wr_a[wr_n] = reg_addr; wr_d[wr_n] = reg_wdata; end
                wr_n++;
                case (reg_addr)
                    5'h1B: p_val = reg_wdata;
                    5'h1C: p_hi  = reg_wdata;
                    5'h1D: p_lo  = reg_wdata;
                    5'h1E: begin
                        if (reg_wdata == 8'h01) p_val = peek({16'd0, p_hi, p_lo});
                        if (reg_wdata == 8'h02) ext_mem[{16'd0, p_hi, p_lo}] = p_val;
                        p_ctrl = reg_wdata;
                        p_left = busy_polls;
                        last_poll = -1;
                    end
                    default: ;
                endcase
            end else begin
                pend = 1 + ($urandom % 3);
                if (reg_addr == 5'h1E) begin
                    poll_n++;
                    if (last_poll >= 0 && (cyc - last_poll) < min_gap) min_gap = cyc - last_poll;
                    last_poll = cyc;
                    pend_data = (p_left == 0) ? 8'h00 : p_ctrl;
                    if (p_left > 0) p_left--;
                end else begin
                    pend_data = p_val;
                end
            end
        end
    end

    // One command end to end, with expectations computed from the requirements.
    task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                          input logic [1:0] lv, input int bp, input int inj);
        logic [4:0] ea [0:15];
        logic [7:0] ed [0:15];
        int         en;
        bit         exp_err;
        logic [7:0] pre, nb, exp_rd;
        int         exp_polls;
        int         n;
        bit         drop;
        string      rq;
        pre = peek((op == 2'b10) ? 32'h0187 : {16'd0, a});
        nb = (pre & 8'h3F) | {lv, 6'b0};
        exp_err = (bp >= TRIES);
        en = 0;
        case (op)
            2'b01: begin
                rq = "R1";
                ea[0] = 5'h1B; ed[0] = d; ea[1] = 5'h1C; ed[1] = a[15:8];
                ea[2] = 5'h1D; ed[2] = a[7:0]; ea[3] = 5'h1E; ed[3] = 8'h02; en = 4;
                exp_rd = 8'h00;
                exp_polls = exp_err ? TRIES : bp + 1;
            end
            2'b00: begin
                rq = "R2";
                ea[0] = 5'h1C; ed[0] = a[15:8]; ea[1] = 5'h1D; ed[1] = a[7:0];
                ea[2] = 5'h1E; ed[2] = 8'h01; en = 3;
                exp_rd = pre;
                exp_polls = exp_err ? TRIES : bp + 1;
            end
            default: begin
                rq = "R5";
                ea[0] = 5'h1C; ed[0] = 8'h01; ea[1] = 5'h1D; ed[1] = 8'h87;
                ea[2] = 5'h1E; ed[2] = 8'h01; en = 3;
                if (!exp_err) begin
                    ea[3] = 5'h1B; ed[3] = nb; ea[4] = 5'h1C; ed[4] = 8'h01;
                    ea[5] = 5'h1D; ed[5] = 8'h87; ea[6] = 5'h1E; ed[6] = 8'h02;
                    ea[7] = 5'h02; ed[7] = 8'h00; en = 8;
                end
                exp_rd = nb;
                exp_polls = exp_err ? TRIES : 2 * (bp + 1);
            end
        endcase
        if (exp_err) rq = "R4";

        busy_polls = bp; wr_n = 0; poll_n = 0; min_gap = 1000000; last_poll = -1;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_level = lv;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'($urandom); req_addr = 16'($urandom);
        req_wdata = 8'($urandom); req_level = 2'($urandom);
        check("R6", "busy after accept", {31'd0, busy}, 1);
        n = 0; drop = 0;
        while (!(done || err) && n < 5000) begin
            if (n == inj) begin
                req_valid = 1'b1; req_op = 2'b01; req_addr = 16'hBEEF; req_wdata = 8'h77;
            end
            @(negedge clk);
            req_valid = 1'b0;
            if (!(done || err) && !busy) drop = 1;
            n++;
        end
        check("R6", "command finished before watchdog", {31'd0, (n < 5000)}, 1);
        check("R6", "busy held until pulse", {31'd0, drop}, 0);
        check("R6", "busy low in pulse cycle", {31'd0, busy}, 0);
        check(rq, "done flag", {31'd0, done}, {31'd0, !exp_err});
        check(rq, "err flag", {31'd0, err}, {31'd0, exp_err});
        check(rq, "rdata", {24'd0, rdata}, exp_err ? 32'd0 : {24'd0, exp_rd});
        check(rq, "write count", wr_n, en);
        for (int i = 0; i < en && i < wr_n; i++) begin
            check(rq, "write address", {27'd0, wr_a[i]}, {27'd0, ea[i]});
            check(rq, "write data", {24'd0, wr_d[i]}, {24'd0, ed[i]});
        end
        check("R3", "poll count", poll_n, exp_polls);
        if (bp > 0) check("R3", "poll spacing >= interval", {31'd0, (min_gap >= CYC)}, 1);
        @(negedge clk);
        check("R6", "pulse is one cycle", {30'd0, done, err}, 0);
        check("R7", "no command started after pulse", {30'd0, busy, reg_valid}, 0);
        check("R8", "rdata zero outside done", {24'd0, rdata}, 0);
        if (inj >= 0) check("R7", "mid-command request had no effect",
                            {31'd0, ext_mem.exists(32'hBEEF)}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R8", "busy in reset", {31'd0, busy}, 0);
        check("R8", "reg_valid in reset", {31'd0, reg_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "idle outputs after reset", {28'd0, busy, done, err, reg_valid}, 0);
        check("R8", "rdata after reset", {24'd0, rdata}, 0);

        // R7: no-operation code is not accepted.
        req_valid = 1'b1; req_op = 2'b11; req_addr = 16'h4444;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R7", "no-op code ignored", {30'd0, busy, reg_valid}, 0);
        end

        // Directed corner cases.
        run_op(2'b01, 16'h1234, 8'hA5, 2'd0, 0, -1);   // R1 plain write
        run_op(2'b00, 16'h1234, 8'h00, 2'd0, 2, -1);   // R2 read back, R3 retries
        check("R2", "read returns written byte via model", {24'd0, peek(32'h1234)}, 32'hA5);
        run_op(2'b00, 16'hFFFF, 8'h00, 2'd0, 4, -1);   // R3 success on last attempt
        run_op(2'b01, 16'h0001, 8'h5A, 2'd0, 5, -1);   // R4 write timeout
        run_op(2'b10, 16'h0000, 8'h00, 2'd2, 1, -1);   // R5 level 2
        run_op(2'b10, 16'h0000, 8'h00, 2'd3, 0, -1);   // R5 level 3
        run_op(2'b10, 16'h0000, 8'h00, 2'd0, 0, -1);   // R5 level 0
        run_op(2'b10, 16'h0000, 8'h00, 2'd1, 5, -1);   // R4 timeout during sensitivity read
        run_op(2'b00, 16'h00A0, 8'h00, 2'd0, 3, 2);    // R7 request while busy

        // Constrained random mix.
        for (int k = 0; k < 40; k++) begin
            logic [1:0] op;
            op = 2'($urandom % 3);
            run_op(op, 16'($urandom), 8'($urandom), 2'($urandom), int'($urandom % 7),
                   (($urandom % 3) == 0) ? int'($urandom % 20) : -1);
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule